// File: doc/BRIEF.md
# Reshapeable Two-Port Synchronous RAM

This block holds 4096 bits of storage behind one write port and one read port. Each port has its own address, so a write and a read can take place in the same cycle. A static parameter sets the shape of the store: 16, 8, 4 or 2 bits per word, with 256, 512, 1024 or 2048 words. Narrower shapes use the same 256-row by 16-bit array. Each row is split into lanes, and the low address bits pick the lane.

The write side registers its data, address and enable on the input clock, gated by an input clock enable. A write strobe taken from the registered enable then commits the word to the array. The read side registers its address and enable on a clock picked by a parameter: the input clock or the output clock. The matching clock enable gates these registers. The block latches read data while the registered read enable is high. An optional output register follows, on the output clock and gated by the output clock enable. A single-port option takes the read address from the write address pin. One asynchronous clear sets every register to zero.

Top module: `cfg_dpram`

## Requirements
- R1: With shape select S (0..3), the word width is 16>>S bits, the word count is 256<<S, and the address width is 8+S bits. Every address up to the last one can be written and read.
- R2: Address a lives in row a>>S, at bit offset (a mod 2^S)·(16>>S). Writing one address leaves the other words of the same row unchanged.
- R3: The write data, write address and write enable are captured on a rising input clock only while the input clock enable is high. While it is low, a write presented at the pins has no effect on memory.
- R4: A write captured at edge k updates the array at input edge k+1. A read address captured at edge k+1 or later returns the new data.
- R5: A read and a write to the same address captured on the same edge return the data that was there before the write. This holds in both dual-port and single-port modes.
- R6: With both clocks the same, a read captured at edge k drives the output at edge k+2 when the output register is used (OUT_REG=1). It drives the output at edge k+1 when the output register is bypassed.
- R7: The output register loads only on output clock edges where the output clock enable is high. Otherwise the output holds.
- R8: While the registered read enable is low, the read data holds its previous value even if the read address changes.
- R9: A high clear sets every register to zero at once, without waiting for a clock, so the output reads zero while clear is high.
- R10: When SINGLE_PORT=1, the read address comes from the write address pin and the read address pin has no effect.
- R11: A write to one address and a read from a different address, captured on the same edge, both complete. The read returns that location's current data.
- R12: RD_CLK_SEL=0 clocks the read address and enable registers with the input clock and gates them with the input clock enable. RD_CLK_SEL=1 uses the output clock and the output clock enable. While the selected enable is low, a new read address is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iclk | input | 1 | Input-side clock (write registers) |
| oclk | input | 1 | Output-side clock (output register) |
| clr | input | 1 | Asynchronous clear of all registers, active high |
| ice | input | 1 | Input clock enable |
| oce | input | 1 | Output clock enable |
| wdata | input | 16>>RATIO_SEL | Write data |
| waddr | input | 8+RATIO_SEL | Write address (also the read address in single-port mode) |
| we | input | 1 | Write enable |
| raddr | input | 8+RATIO_SEL | Read address |
| re | input | 1 | Read enable |
| rdata | output | 16>>RATIO_SEL | Read data |

## Verification
The bench targets these corner cases:
- **Same-address collision (R5):** a read and a write to one address on the same edge. A design that forwards the write data would return the new word here instead of the old one.
- **Read right after a write (R4):** a design with a slow write strobe would return stale data.
- **Narrow shape (R2):** a word is rewritten between its neighbours in the same row. A wrong lane offset or a full-row write would corrupt the neighbours.
- **Enables and mode pins (R3, R7, R8, R10, R12):** each enable is held low, read enable is dropped, or the unused address pin is driven with junk. A leaky enable, or a mux with the wrong sense, shows up as a changed output.
- **Mid-run clear (R9):** a clear asserted between clock edges must zero the output at once. A synchronous clear would not.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;
  localparam int ROW_BITS  = 16;
  localparam int ROW_COUNT = 256;
  localparam int ROW_AW    = 8;

  // word width for a shape select
  function automatic int data_width(input int sel);
    return ROW_BITS >> sel;
  endfunction

  // address width for a shape select
  function automatic int addr_width(input int sel);
    return ROW_AW + sel;
  endfunction

  // log2 of the word width: lane index shifted by this gives the bit offset
  function automatic int lane_shift(input int sel);
    return 4 - sel;
  endfunction
endpackage

// File: rtl/cfg_dpram_wr_port.sv
module cfg_dpram_wr_port #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          iclk,
  input  logic          clr,
  input  logic          ice,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] waddr,
  input  logic          we,
  output logic [DW-1:0] wd_q,
  output logic [AW-1:0] wa_q,
  output logic          wr_pulse
);
  logic we_q;

  always_ff @(posedge iclk or posedge clr) begin
    if (clr) begin
      wd_q <= '0;
      wa_q <= '0;
      we_q <= 1'b0;
    end else if (ice) begin
      wd_q <= wdata;
      wa_q <= waddr;
      we_q <= we;
    end
  end

  // strobe that commits the registered word on the following input edge
  assign wr_pulse = we_q;

  // R3
  wr_hold_chk: assert property (@(posedge iclk) disable iff (clr)
    !ice |=> ($stable(wa_q) && $stable(wd_q) && $stable(we_q)));
endmodule

// File: rtl/cfg_dpram_rd_port.sv
module cfg_dpram_rd_port #(
  parameter int AW          = 8,
  parameter bit RD_CLK_SEL  = 1'b0,
  parameter bit SINGLE_PORT = 1'b0
) (
  input  logic          iclk,
  input  logic          oclk,
  input  logic          clr,
  input  logic          ice,
  input  logic          oce,
  input  logic [AW-1:0] raddr,
  input  logic [AW-1:0] waddr,
  input  logic          re,
  output logic          rd_clk,
  output logic [AW-1:0] ra_q,
  output logic          re_q
);
  logic          rd_ce;
  logic [AW-1:0] ra_in;

  // static clock/enable choice for the read request registers
  assign rd_clk = RD_CLK_SEL ? oclk : iclk;
  assign rd_ce  = RD_CLK_SEL ? oce  : ice;
  assign ra_in  = SINGLE_PORT ? waddr : raddr;

  always_ff @(posedge rd_clk or posedge clr) begin
    if (clr) begin
      ra_q <= '0;
      re_q <= 1'b0;
    end else if (rd_ce) begin
      ra_q <= ra_in;
      re_q <= re;
    end
  end

  // R12
  rd_req_hold_chk: assert property (@(posedge rd_clk) disable iff (clr)
    !rd_ce |=> ($stable(ra_q) && $stable(re_q)));
endmodule

// File: rtl/cfg_dpram_store.sv
module cfg_dpram_store #(
  parameter int SEL = 0,
  parameter int DW  = cfg_dpram_pkg::data_width(SEL),
  parameter int AW  = cfg_dpram_pkg::addr_width(SEL)
) (
  input  logic          iclk,
  input  logic          rd_clk,
  input  logic          clr,
  input  logic          wr_pulse,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  input  logic          re_q,
  output logic [DW-1:0] rd_lat
);
  localparam int RAW   = cfg_dpram_pkg::ROW_AW;
  localparam int ROWS  = cfg_dpram_pkg::ROW_COUNT;
  localparam int RBITS = cfg_dpram_pkg::ROW_BITS;
  localparam int SHIFT = cfg_dpram_pkg::lane_shift(SEL);

  logic [RBITS-1:0] mem [ROWS];
  logic [RAW-1:0]   w_row, r_row;
  logic [3:0]       w_off, r_off;

  // row = upper address bits, lane = lower SEL bits
  assign w_row = wa[AW-1 -: RAW];
  assign r_row = ra[AW-1 -: RAW];

  if (SEL == 0) begin : g_full_row
    assign w_off = 4'd0;
    assign r_off = 4'd0;
  end else begin : g_lanes
    assign w_off = 4'(wa[SEL-1:0]) << SHIFT;
    assign r_off = 4'(ra[SEL-1:0]) << SHIFT;
  end

  always_ff @(posedge iclk) begin
    if (wr_pulse)
      mem[w_row][w_off +: DW] <= wd;
  end

  always_ff @(posedge rd_clk or posedge clr) begin
    if (clr)
      rd_lat <= '0;
    else if (re_q)
      rd_lat <= mem[r_row][r_off +: DW];
  end

  // R8
  rd_idle_hold_chk: assert property (@(posedge rd_clk) disable iff (clr)
    !re_q |=> $stable(rd_lat));
endmodule

// File: rtl/cfg_dpram_out.sv
module cfg_dpram_out #(
  parameter int DW      = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          oclk,
  input  logic          clr,
  input  logic          oce,
  input  logic [DW-1:0] rd_lat,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] dout_q;

  always_ff @(posedge oclk or posedge clr) begin
    if (clr)
      dout_q <= '0;
    else if (oce)
      dout_q <= rd_lat;
  end

  assign rdata = OUT_REG ? dout_q : rd_lat;

  // R7
  out_hold_chk: assert property (@(posedge oclk) disable iff (clr)
    !oce |=> $stable(dout_q));
endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram #(
  parameter int RATIO_SEL   = 0,
  parameter bit OUT_REG     = 1'b1,
  parameter bit RD_CLK_SEL  = 1'b0,
  parameter bit SINGLE_PORT = 1'b0,
  localparam int DW = cfg_dpram_pkg::data_width(RATIO_SEL),
  localparam int AW = cfg_dpram_pkg::addr_width(RATIO_SEL)
) (
  input  logic          iclk,
  input  logic          oclk,
  input  logic          clr,
  input  logic          ice,
  input  logic          oce,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] waddr,
  input  logic          we,
  input  logic [AW-1:0] raddr,
  input  logic          re,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] wd_q, rd_lat;
  logic [AW-1:0] wa_q, ra_q;
  logic          wr_pulse, re_q, rd_clk;

  cfg_dpram_wr_port #(.DW(DW), .AW(AW)) u_wr (
    .iclk(iclk), .clr(clr), .ice(ice), .wdata(wdata), .waddr(waddr),
    .we(we), .wd_q(wd_q), .wa_q(wa_q), .wr_pulse(wr_pulse));

  cfg_dpram_rd_port #(.AW(AW), .RD_CLK_SEL(RD_CLK_SEL), .SINGLE_PORT(SINGLE_PORT)) u_rd (
    .iclk(iclk), .oclk(oclk), .clr(clr), .ice(ice), .oce(oce),
    .raddr(raddr), .waddr(waddr), .re(re),
    .rd_clk(rd_clk), .ra_q(ra_q), .re_q(re_q));

  cfg_dpram_store #(.SEL(RATIO_SEL), .DW(DW), .AW(AW)) u_store (
    .iclk(iclk), .rd_clk(rd_clk), .clr(clr), .wr_pulse(wr_pulse),
    .wa(wa_q), .wd(wd_q), .ra(ra_q), .re_q(re_q), .rd_lat(rd_lat));

  cfg_dpram_out #(.DW(DW), .OUT_REG(OUT_REG)) u_out (
    .oclk(oclk), .clr(clr), .oce(oce), .rd_lat(rd_lat), .rdata(rdata));

  // R9
  clr_zero_chk: assert property (@(posedge oclk) clr |-> (rdata == '0));
endmodule

// File: tb/cfg_dpram_bench.sv
`timescale 1ns/1ps
module cfg_dpram_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic clr;
  int n_cmp = 0, n_bad = 0;

  // instance A: 256x16, registered output, read regs on input clock
  logic a_ice, a_oce, a_we, a_re;
  logic [15:0] a_wd, a_dout;
  logic [7:0]  a_wa, a_ra;
  // instance B: 1024x4, bypassed output, read regs on output clock, single port
  logic b_ice, b_oce, b_we, b_re;
  logic [3:0] b_wd, b_dout;
  logic [9:0] b_wa, b_ra;

  cfg_dpram #(.RATIO_SEL(0), .OUT_REG(1'b1), .RD_CLK_SEL(1'b0), .SINGLE_PORT(1'b0)) u_cfg_dpram (
    .iclk(clk), .oclk(clk), .clr(clr), .ice(a_ice), .oce(a_oce), .wdata(a_wd),
    .waddr(a_wa), .we(a_we), .raddr(a_ra), .re(a_re), .rdata(a_dout));

  cfg_dpram #(.RATIO_SEL(2), .OUT_REG(1'b0), .RD_CLK_SEL(1'b1), .SINGLE_PORT(1'b1)) u_cfg_dpram_sp (
    .iclk(clk), .oclk(clk), .clr(clr), .ice(b_ice), .oce(b_oce), .wdata(b_wd),
    .waddr(b_wa), .we(b_we), .raddr(b_ra), .re(b_re), .rdata(b_dout));

  logic [15:0] a_mdl [256];
  logic [3:0]  b_mdl [1024];
  logic [15:0] a_q[$];
  string       a_qr[$];
  logic [3:0]  b_q[$];
  string       b_qr[$];
  bit a_scb = 1'b0, b_scb = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor A: result two edges after capture
  initial begin
    bit p0, p1, p2;
    logic [15:0] e;
    string r;
    p0 = 0; p1 = 0; p2 = 0;
    forever begin
      @(posedge clk);
      p2 = p1; p1 = p0; p0 = a_scb && a_re && a_ice && !clr;
      #5;
      if (p2) begin
        if (a_q.size() == 0) chk(1'b0, "R6 unexpected result A", a_dout, 16'h0);
        else begin
          e = a_q.pop_front(); r = a_qr.pop_front();
          chk(a_dout === e, r, a_dout, e);
        end
      end
    end
  end

  // monitor B: result one edge after capture
  initial begin
    bit p0, p1;
    logic [3:0] e;
    string r;
    p0 = 0; p1 = 0;
    forever begin
      @(posedge clk);
      p1 = p0; p0 = b_scb && b_re && b_oce && !clr;
      #5;
      if (p1) begin
        if (b_q.size() == 0) chk(1'b0, "R6 unexpected result B", {12'h0, b_dout}, 16'h0);
        else begin
          e = b_q.pop_front(); r = b_qr.pop_front();
          chk(b_dout === e, r, {12'h0, b_dout}, {12'h0, e});
        end
      end
    end
  end

  task automatic a_drive(input bit we, input logic [7:0] wa, input logic [15:0] wd,
                         input bit re, input logic [7:0] ra);
    @(negedge clk);
    a_we = we; a_wa = wa; a_wd = wd; a_re = re; a_ra = ra;
  endtask
  task automatic a_wr(input logic [7:0] ad, input logic [15:0] d);
    a_drive(1'b1, ad, d, 1'b0, 8'h0); a_mdl[ad] = d;
  endtask
  task automatic a_rd(input logic [7:0] ad, input string req);
    a_drive(1'b0, 8'h0, 16'h0, 1'b1, ad);
    a_q.push_back(a_mdl[ad]); a_qr.push_back(req);
  endtask
  task automatic a_rw(input logic [7:0] wa, input logic [15:0] d, input logic [7:0] ra, input string req);
    a_drive(1'b1, wa, d, 1'b1, ra);
    a_q.push_back(a_mdl[ra]); a_qr.push_back(req); a_mdl[wa] = d;
  endtask
  task automatic a_idle(input int n);
    repeat (n) a_drive(1'b0, 8'h0, 16'h0, 1'b0, 8'h0);
  endtask

  task automatic b_drive(input bit we, input logic [9:0] ad, input logic [3:0] wd, input bit re);
    @(negedge clk);
    b_we = we; b_wa = ad; b_wd = wd; b_re = re; b_ra = ~ad;  // junk on the unused pin
  endtask
  task automatic b_wr(input logic [9:0] ad, input logic [3:0] d);
    b_drive(1'b1, ad, d, 1'b0); b_mdl[ad] = d;
  endtask
  task automatic b_rd(input logic [9:0] ad, input string req);
    b_drive(1'b0, ad, 4'h0, 1'b1);
    b_q.push_back(b_mdl[ad]); b_qr.push_back(req);
  endtask
  task automatic b_rw(input logic [9:0] ad, input logic [3:0] d, input string req);
    b_drive(1'b1, ad, d, 1'b1);
    b_q.push_back(b_mdl[ad]); b_qr.push_back(req); b_mdl[ad] = d;
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clr = 1'b1;
    a_ice = 1; a_oce = 1; a_we = 0; a_re = 0; a_wd = '0; a_wa = '0; a_ra = '0;
    b_ice = 1; b_oce = 1; b_we = 0; b_re = 0; b_wd = '0; b_wa = '0; b_ra = '0;
    #5;
    chk(a_dout == 16'h0, "R9 reset state A", a_dout, 16'h0);
    chk(b_dout == 4'h0, "R9 reset state B", {12'h0, b_dout}, 16'h0);
    repeat (2) @(negedge clk);
    clr = 1'b0;
    a_idle(1);

    // instance A scoreboard
    a_scb = 1'b1;
    a_wr(8'h00, 16'h1234); a_wr(8'hFF, 16'hBEEF); a_wr(8'h5A, 16'h0F0F); a_wr(8'h11, 16'h1111);
    a_rd(8'h00, "R6 word 0");
    a_rd(8'hFF, "R1 top address A");
    a_rd(8'h5A, "R6 word 5A");
    a_wr(8'h11, 16'hCAFE);
    a_rd(8'h11, "R4 read right after write");
    a_rw(8'h22, 16'hA5A5, 8'hFF, "R11 concurrent read other address");
    a_rd(8'h22, "R11 word written during read");
    a_rw(8'h5A, 16'h7777, 8'h5A, "R5 collision returns old data");
    a_rd(8'h5A, "R5 new data after collision");
    a_idle(4);
    chk(a_q.size() == 0, "R6 A results drained", 16'(a_q.size()), 16'h0);
    a_scb = 1'b0;

    // R8: read enable low holds data while address moves
    a_drive(1'b0, 8'h0, 16'h0, 1'b1, 8'hFF);
    repeat (4) a_drive(1'b0, 8'h0, 16'h0, 1'b0, 8'h00);
    @(negedge clk);
    chk(a_dout == 16'hBEEF, "R8 hold with read enable low", a_dout, 16'hBEEF);

    // R7: output enable low freezes output
    a_oce = 1'b0;
    repeat (4) a_drive(1'b0, 8'h0, 16'h0, 1'b1, 8'h00);
    chk(a_dout == 16'hBEEF, "R7 output frozen while oce low", a_dout, 16'hBEEF);
    a_oce = 1'b1;
    repeat (2) a_drive(1'b0, 8'h0, 16'h0, 1'b1, 8'h00);
    chk(a_dout == 16'h1234, "R7 output loads after oce high", a_dout, 16'h1234);

    // R12: instance A read regs gated by input enable
    @(negedge clk); a_ice = 1'b0; a_ra = 8'hFF; a_re = 1'b1;
    repeat (4) @(negedge clk);
    chk(a_dout == 16'h1234, "R12 read address blocked by ice low", a_dout, 16'h1234);

    // R3: write ignored while input enable low
    a_we = 1'b1; a_wa = 8'h00; a_wd = 16'hDEAD; a_re = 1'b0;
    repeat (3) @(negedge clk);
    a_we = 1'b0; a_ice = 1'b1;
    a_idle(2);
    a_scb = 1'b1;
    a_rd(8'h00, "R3 write ignored while ice low");
    a_idle(4);
    a_scb = 1'b0;

    // instance B scoreboard (4-bit lanes, single port)
    b_scb = 1'b1;
    b_wr(10'd0, 4'h3); b_wr(10'd1, 4'hA); b_wr(10'd2, 4'h5); b_wr(10'd3, 4'hC); b_wr(10'd1023, 4'h9);
    b_rd(10'd0, "R2 lane 0"); b_rd(10'd1, "R2 lane 1"); b_rd(10'd2, "R2 lane 2");
    b_rd(10'd3, "R10 read address pin ignored");
    b_rd(10'd1023, "R1 deepest address B");
    b_wr(10'd1, 4'h6);
    b_rd(10'd0, "R2 lower neighbour untouched");
    b_rd(10'd1, "R2 lane rewrite");
    b_rd(10'd2, "R2 upper neighbour untouched");
    b_rw(10'd2, 4'hE, "R5 single-port collision old data");
    b_rd(10'd2, "R5 single-port new data");
    repeat (3) b_drive(1'b0, 10'd0, 4'h0, 1'b0);
    chk(b_q.size() == 0, "R6 B results drained", 16'(b_q.size()), 16'h0);
    b_scb = 1'b0;

    // R12: instance B read regs gated by output enable
    repeat (3) b_drive(1'b0, 10'd3, 4'h0, 1'b1);
    chk(b_dout == 4'hC, "R12 B baseline", {12'h0, b_dout}, 16'h000C);
    b_oce = 1'b0;
    repeat (4) b_drive(1'b0, 10'd1023, 4'h0, 1'b1);
    chk(b_dout == 4'hC, "R12 read address blocked by oce low", {12'h0, b_dout}, 16'h000C);
    b_oce = 1'b1;
    repeat (2) b_drive(1'b0, 10'd1023, 4'h0, 1'b1);
    chk(b_dout == 4'h9, "R12 read resumes with oce high", {12'h0, b_dout}, 16'h0009);

    // R9: clear between edges zeroes outputs at once
    @(negedge clk); #3 clr = 1'b1;
    #1;
    chk(a_dout == 16'h0, "R9 async clear A", a_dout, 16'h0);
    chk(b_dout == 4'h0, "R9 async clear B", {12'h0, b_dout}, 16'h0);
    @(negedge clk); clr = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule